// File: doc/BRIEF.md
# Partitioned Pixel Add/Compare Unit

This unit is a small SIMD integer datapath for packed pixel data. It treats a 64-bit operand as four 16-bit lanes or as two 32-bit lanes. On those lanes it can add, subtract or compare. It can also widen four packed bytes into four 16-bit lanes that carry 4 fractional bits. A single-register form limits add and subtract to the low 32 bits of the operands and clears the upper half of the result.

A caller presents two operands together with an opcode, a condition select and two width controls, and raises `in_valid` for one cycle. The result is registered. It appears one cycle later with `out_valid` and stays unchanged until the next strobe.

Compares do not return lane-wide masks. They return a packed bitmask with one bit per lane, and every other result bit is zero. Saturation and condition codes are not part of this unit.

Top module: `pix_simd_alu`

## Requirements
- R1: With opcode 3'b000, the unit adds `src_a` and `src_b` lane by lane. Lanes are 16 bits when `wide_lane`=0. Each lane wraps modulo 2^16, and no carry passes into the next lane.
- R2: With opcode 3'b001, each lane holds `src_a` minus `src_b`, wrapping modulo the lane width, with no borrow between lanes.
- R3: When `wide_lane`=1, add and subtract use two 32-bit lanes, bits 31:0 and 63:32, and each lane wraps modulo 2^32.
- R4: When `half_word`=1, add and subtract act only on bits 31:0 of the operands, using the selected lane width, and result bits 63:32 are zero.
- R5: With opcode 3'b010 and `wide_lane`=0, result bit i (i = 0..3) is set when 16-bit lane i of `src_a` meets the condition against lane i of `src_b`. Bits 63:4 are zero.
- R6: With opcode 3'b010 and `wide_lane`=1, result bits 0 and 1 come from the two 32-bit lanes, and bits 63:2 are zero.
- R7: Compares are unsigned. The `cond` encodings are 2'b00 greater-than, 2'b01 equal, 2'b10 less-or-equal and 2'b11 not-equal.
- R8: With opcode 3'b011, byte i of `src_a[31:0]` is written to bits 11:4 of 16-bit result lane i. The top 4 bits and the low 4 bits of each lane are zero.
- R9: Opcodes 3'b100 to 3'b111 give a result of zero.
- R10: A strobe on `in_valid` produces the result and `out_valid`=1 on the next cycle. Without a strobe, `out_valid` is 0 on the next cycle and `result` keeps its value.
- R11: After reset, `result` is zero and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input strobe |
| opcode | input | 3 | Operation: add, sub, compare, expand, or an unused code |
| cond | input | 2 | Compare condition |
| wide_lane | input | 1 | 0: 16-bit lanes, 1: 32-bit lanes |
| half_word | input | 1 | Single-register (32-bit) form for add and subtract |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Registered result |

## Verification
The assertions check structural properties of the registered result on every cycle:
- the one-cycle valid handshake and the hold of `result` between strobes;
- zero upper bits after a compare or a single-register operation;
- the zero nibbles around each expanded byte;
- a zero result for unused opcodes.

Only the directed scenarios show that the values themselves are right. These include lane wrap without carry or borrow, the unsigned ordering of compares for every condition, and the placement of each byte in an expansion.

// File: rtl/pix_simd_alu.sv
module pix_simd_alu #(
  parameter int W      = 64,
  parameter int NARROW = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [2:0]   opcode,
  input  logic [1:0]   cond,
  input  logic         wide_lane,
  input  logic         half_word,
  input  logic [W-1:0] src_a,
  input  logic [W-1:0] src_b,
  output logic         out_valid,
  output logic [W-1:0] result
);
  localparam int WIDE = 2 * NARROW;
  localparam int NN   = W / NARROW;
  localparam int NW   = W / WIDE;
  localparam int HALF = W / 2;

  localparam logic [2:0] OP_ADD = 3'b000;
  localparam logic [2:0] OP_SUB = 3'b001;
  localparam logic [2:0] OP_CMP = 3'b010;
  localparam logic [2:0] OP_EXP = 3'b011;

  function automatic logic hit(input logic [WIDE-1:0] x, input logic [WIDE-1:0] y,
                               input logic [1:0] c);
    case (c)
      2'b00:   return x > y;
      2'b01:   return x == y;
      2'b10:   return x <= y;
      default: return x != y;
    endcase
  endfunction

  logic [W-1:0] arith_n, arith_w, cmp_n, cmp_w, expd, nxt;

  always_comb begin
    arith_n = '0;
    arith_w = '0;
    cmp_n   = '0;
    cmp_w   = '0;
    expd    = '0;
    for (int i = 0; i < NN; i++) begin
      arith_n[i*NARROW +: NARROW] = (opcode == OP_SUB)
        ? src_a[i*NARROW +: NARROW] - src_b[i*NARROW +: NARROW]
        : src_a[i*NARROW +: NARROW] + src_b[i*NARROW +: NARROW];
      cmp_n[i] = hit(WIDE'(src_a[i*NARROW +: NARROW]), WIDE'(src_b[i*NARROW +: NARROW]), cond);
      expd[i*NARROW +: NARROW] = NARROW'({src_a[i*8 +: 8], 4'b0000});
    end
    for (int j = 0; j < NW; j++) begin
      arith_w[j*WIDE +: WIDE] = (opcode == OP_SUB)
        ? src_a[j*WIDE +: WIDE] - src_b[j*WIDE +: WIDE]
        : src_a[j*WIDE +: WIDE] + src_b[j*WIDE +: WIDE];
      cmp_w[j] = hit(src_a[j*WIDE +: WIDE], src_b[j*WIDE +: WIDE], cond);
    end
  end

  logic [W-1:0] arith;
  assign arith = (wide_lane ? arith_w : arith_n) & (half_word ? {{HALF{1'b0}}, {HALF{1'b1}}} : {W{1'b1}});

  always_comb begin
    case (opcode)
      OP_ADD, OP_SUB: nxt = arith;
      OP_CMP:         nxt = wide_lane ? cmp_w : cmp_n;
      OP_EXP:         nxt = expd;
      default:        nxt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= nxt;
    end
  end

  assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result)));
  assert_cmp16_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == OP_CMP && !wide_lane) |=> (result[W-1:NN] == '0));
  assert_cmp32_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == OP_CMP && wide_lane) |=> (result[W-1:NW] == '0));
  assert_single_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && half_word && (opcode == OP_ADD || opcode == OP_SUB)) |=> (result[W-1:HALF] == '0));
  assert_expand_nibbles_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == OP_EXP) |=> ((result & {NN{{(NARROW-12){1'b1}}, 8'h00, 4'hF}}) == '0));
  assert_unused_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode[2]) |=> (result == '0));
endmodule

// File: tb/tb_pix_simd_alu.sv
module tb_pix_simd_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  opcode = '0;
  logic [1:0]  cond = '0;
  logic        wide_lane = 1'b0;
  logic        half_word = 1'b0;
  logic [63:0] src_a = '0;
  logic [63:0] src_b = '0;
  logic        out_valid;
  logic [63:0] result;

  int vecs = 0;
  int errs = 0;

  always #5 clk = ~clk;

  pix_simd_alu dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode), .cond(cond),
    .wide_lane(wide_lane), .half_word(half_word), .src_a(src_a), .src_b(src_b),
    .out_valid(out_valid), .result(result)
  );

  function automatic logic rel(input logic [31:0] x, input logic [31:0] y, input logic [1:0] c);
    if (c == 2'b00) return x > y;
    if (c == 2'b01) return x == y;
    if (c == 2'b10) return x <= y;
    return x != y;
  endfunction

  function automatic logic [63:0] model(input logic [2:0] op, input logic [1:0] c, input logic wl,
                                        input logic hw, input logic [63:0] a, input logic [63:0] b);
    logic [63:0] r = '0;
    int lw = wl ? 32 : 16;
    int n = 64 / lw;
    if (op == 3'b000 || op == 3'b001) begin
      for (int i = 0; i < n; i++) begin
        logic [31:0] x = 32'((a >> (i*lw)) & ((64'd1 << lw) - 1));
        logic [31:0] y = 32'((b >> (i*lw)) & ((64'd1 << lw) - 1));
        logic [31:0] s = (op == 3'b000) ? x + y : x - y;
        r = r | ((64'(s) & ((64'd1 << lw) - 1)) << (i*lw));
      end
      if (hw) r[63:32] = '0;
    end else if (op == 3'b010) begin
      for (int i = 0; i < n; i++) begin
        logic [31:0] x = 32'((a >> (i*lw)) & ((64'd1 << lw) - 1));
        logic [31:0] y = 32'((b >> (i*lw)) & ((64'd1 << lw) - 1));
        r[i] = rel(x, y, c);
      end
    end else if (op == 3'b011) begin
      for (int i = 0; i < 4; i++) r = r | (64'(a[i*8 +: 8]) << (i*16 + 4));
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    vecs++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(input string req, input logic [2:0] op, input logic [1:0] c, input logic wl,
                       input logic hw, input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    opcode = op; cond = c; wide_lane = wl; half_word = hw; src_a = a; src_b = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, 64'(out_valid), 64'd1);
    check(req, result, model(op, c, wl, hw, a, b));
  endtask

  task automatic t_reset;
    check("R11 result", result, 64'd0);
    check("R11 valid", 64'(out_valid), 64'd0);
  endtask

  task automatic t_add_sub;
    apply("R1 add carry stop", 3'b000, 2'b00, 1'b0, 1'b0, 64'h0001_7FFF_8000_FFFF, 64'hFFFF_0001_8000_0001);
    check("R1 add value", result, 64'h0000_8000_0000_0000);
    apply("R1 add mix", 3'b000, 2'b00, 1'b0, 1'b0, 64'h1234_5678_9ABC_DEF0, 64'h1111_2222_3333_4444);
    apply("R2 sub borrow stop", 3'b001, 2'b00, 1'b0, 1'b0, 64'h0000_0005_0000_1000, 64'h0001_0003_0000_0001);
    check("R2 sub value", result, 64'hFFFF_0002_0000_0FFF);
  endtask

  task automatic t_wide;
    apply("R3 add32", 3'b000, 2'b00, 1'b1, 1'b0, 64'h0000_0001_FFFF_FFFF, 64'h0000_0001_0000_0001);
    check("R3 add32 value", result, 64'h0000_0002_0000_0000);
    apply("R3 sub32", 3'b001, 2'b00, 1'b1, 1'b0, 64'h0000_0000_0001_0000, 64'h0000_0001_0000_0001);
  endtask

  task automatic t_single;
    apply("R4 add16s", 3'b000, 2'b00, 1'b0, 1'b1, 64'hAAAA_BBBB_FFFF_0001, 64'h1111_1111_0001_FFFF);
    check("R4 add16s value", result, 64'h0000_0000_0000_0000);
    apply("R4 sub32s", 3'b001, 2'b00, 1'b1, 1'b1, 64'hDEAD_BEEF_0000_0000, 64'h1234_5678_0000_0001);
    check("R4 sub32s value", result, 64'h0000_0000_FFFF_FFFF);
  endtask

  task automatic t_cmp;
    for (int c = 0; c < 4; c++) begin
      apply("R5 R7 cmp16", 3'b010, 2'(c), 1'b0, 1'b0, 64'h8000_0005_0005_0001, 64'h0001_0005_0006_8000);
      apply("R6 R7 cmp32", 3'b010, 2'(c), 1'b1, 1'b0, 64'h8000_0000_1234_5678, 64'h0000_0001_1234_5678);
    end
    apply("R7 unsigned gt", 3'b010, 2'b00, 1'b0, 1'b0, 64'h0000_0000_0000_8000, 64'h0000_0000_0000_0001);
    check("R7 unsigned gt value", result, 64'h1);
    apply("R5 ne all", 3'b010, 2'b11, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0);
    check("R5 ne all value", result, 64'hF);
  endtask

  task automatic t_expand;
    apply("R8 expand", 3'b011, 2'b00, 1'b0, 1'b0, 64'hFFFF_FFFF_FF80_01A5, 64'h0);
    check("R8 expand value", result, 64'h0FF0_0800_0010_0A50);
  endtask

  task automatic t_unused;
    for (int op = 4; op < 8; op++)
      apply("R9 unused", 3'(op), 2'b01, 1'b0, 1'b0, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0);
  endtask

  task automatic t_hold;
    logic [63:0] keep;
    apply("R10 strobe", 3'b000, 2'b00, 1'b0, 1'b0, 64'h0000_0000_0000_0042, 64'h1);
    keep = result;
    @(negedge clk);
    opcode = 3'b001; src_a = 64'hFFFF; src_b = 64'h1;
    @(negedge clk);
    check("R10 idle valid", 64'(out_valid), 64'd0);
    check("R10 idle hold", result, keep);
  endtask

  initial begin
    #1000000;
    errs++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_add_sub();
    t_wide();
    t_single();
    t_cmp();
    t_expand();
    t_unused();
    t_hold();
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule